// File: doc/BRIEF.md
# Pattern-Triggered Capture Front End

This block sits behind a deserialized differential-pair receiver channel. Each reference-clock cycle with a valid strobe, it takes one sample from the receiver's 21-bit output. Only the low 14 bits carry data, and the upper 7 are not used. The block waits for a programmable start pattern, then keeps only the samples that pass a second, storage pattern. Each kept sample is widened to 16 bits with a parity bit and a start marker. Kept samples are packed two to a 32-bit word and written into a downstream FIFO, such as one 1K x 32 buffer per channel.

Each pattern is a 14-bit compare value plus a 14-bit care mask. A sample hits when `(sample ^ value) & mask` is zero, so an all-zero mask hits every sample. The control state machine has three states:

- `S_IDLE`: the block waits for an arm pulse.
- `S_ARMED`: the block looks for the start pattern.
- `S_CAPTURE`: the block stores the samples that pass the storage pattern.

The transitions are:

- **arm**: `S_IDLE`→`S_ARMED`.
- **trigger**: `S_ARMED`→`S_CAPTURE`.
- **disarm**: `S_ARMED`→`S_IDLE` and `S_CAPTURE`→`S_IDLE`.

Top module: `trig_capture_fe`

## Requirements
- R1: After reset, `fifo_wr`, `armed`, `triggered` and `overflow` are all 0.
- R2: An `arm` pulse in `S_IDLE` without `disarm` sets `armed` from the next cycle and clears `overflow`. An `arm` in `S_ARMED` or `S_CAPTURE` has no effect.
- R3: The start match uses only `in_data[13:0]`, and bits [20:14] are ignored. It is evaluated only in `S_ARMED` on a valid sample. On a hit, `triggered` becomes 1 from the next cycle.
- R4: No sample is stored before the trigger. The trigger sample itself and every later valid sample are stored exactly when they hit the storage pattern. A zero storage mask stores all of them.
- R5: A stored half-word is laid out as follows:
  - bits [13:0] hold the data.
  - bit 14 holds the parity. With `odd_parity`=0 it is the XOR of the 14 data bits (even parity). With `odd_parity`=1 it is that XOR inverted.
  - bit 15 is 1 only on the first stored sample after a trigger.
- R6: The first stored sample of a pair goes to `fifo_data[15:0]` and the second to `fifo_data[31:16]`. `fifo_wr` pulses for one cycle after the clock edge that takes in the second sample.
- R7: `disarm` in `S_ARMED` or `S_CAPTURE` returns the block to `S_IDLE`. A pending lone half-word is written as `{16'h0, half}`. A sample offered in the same cycle as `disarm` is not stored, and `disarm` wins over `arm`.
- R8: If `fifo_full` is high in the cycle a word becomes ready, that word is dropped and `overflow` goes to 1. `overflow` stays at 1 until the next accepted arm.
- R9: A cycle with `in_valid`=0 neither triggers nor stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 21 | Receiver output; only bits [13:0] are used |
| start_value | input | 14 | Start pattern compare value |
| start_mask | input | 14 | Start pattern care mask |
| store_value | input | 14 | Storage pattern compare value |
| store_mask | input | 14 | Storage pattern care mask |
| odd_parity | input | 1 | 1 selects odd parity |
| arm | input | 1 | Arm pulse |
| disarm | input | 1 | Disarm pulse, with flush |
| fifo_full | input | 1 | FIFO full flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO write word |
| armed | output | 1 | 1 in `S_ARMED` or `S_CAPTURE` |
| triggered | output | 1 | 1 in `S_CAPTURE` |
| overflow | output | 1 | Sticky word-dropped flag |

## Verification
Two pairs of functions can land in the same cycle.

- **Trigger detection and the storage decision.** The trigger sample must be filtered and stored, with its marker, in the very cycle it moves the state machine. The bench provokes this with samples that hit both patterns, and with others that hit only the start pattern.
- **Pair completion and FIFO full.** `fifo_full` is raised exactly when a second half-word arrives, or when a disarm flushes a half-word.

A bench model built from the requirements judges each cycle: the write strobe, the packed word, and the sticky overflow flag. Random masks with few care bits keep both kinds of hit frequent.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ARMED   = 2'd1,
        S_CAPTURE = 2'd2
    } cap_state_t;

    localparam int unsigned N_PAT = 2;   // pattern units
    localparam int unsigned P_START = 0; // index of the start pattern
    localparam int unsigned P_STORE = 1; // index of the storage pattern
endpackage

// File: rtl/tcf_match.sv
module tcf_match #(
    parameter int unsigned W = 14
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] value,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (sample ^ value) & mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/tcf_widen.sv
module tcf_widen #(
    parameter int unsigned W = 14
) (
    input  logic [W-1:0] data,
    input  logic         odd_sel,
    input  logic         mark,
    output logic [W+1:0] half
);
    logic par;

    always_comb begin
        par  = (^data) ^ odd_sel;
        half = {mark, par, data};
    end
endmodule

// File: rtl/tcf_packer.sv
module tcf_packer #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_ovf,
    input  logic              store_en,
    input  logic [HALF_W-1:0] store_half,
    input  logic              flush,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overflow,
    output logic              half_valid
);
    logic [HALF_W-1:0] half_q;
    logic              word_rdy;
    logic [WORD_W-1:0] word_nx;

    always_comb begin
        word_rdy = 1'b0;
        word_nx  = '0;
        if (flush) begin
            word_rdy = half_valid;
            word_nx  = {{HALF_W{1'b0}}, half_q};
        end else if (store_en && half_valid) begin
            word_rdy = 1'b1;
            word_nx  = {store_half, half_q};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q     <= '0;
            half_valid <= 1'b0;
            fifo_wr    <= 1'b0;
            fifo_data  <= '0;
            overflow   <= 1'b0;
        end else begin
            fifo_wr <= 1'b0;
            if (clr_ovf) begin
                overflow <= 1'b0;
            end
            if (flush) begin
                half_valid <= 1'b0;
            end else if (store_en) begin
                if (!half_valid) begin
                    half_q     <= store_half;
                    half_valid <= 1'b1;
                end else begin
                    half_valid <= 1'b0;
                end
            end
            if (word_rdy) begin
                if (fifo_full) begin
                    overflow <= 1'b1;
                end else begin
                    fifo_wr   <= 1'b1;
                    fifo_data <= word_nx;
                end
            end
        end
    end

    AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !$past(fifo_full)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow && !clr_ovf) |-> overflow); // R8
endmodule

// File: rtl/trig_capture_fe.sv
module trig_capture_fe
    import tcf_pkg::*;
#(
    parameter int unsigned DATA_W = 14,
    parameter int unsigned RAW_W  = 21,
    localparam int unsigned HALF_W = DATA_W + 2,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_data,
    input  logic [DATA_W-1:0] start_value,
    input  logic [DATA_W-1:0] start_mask,
    input  logic [DATA_W-1:0] store_value,
    input  logic [DATA_W-1:0] store_mask,
    input  logic              odd_parity,
    input  logic              arm,
    input  logic              disarm,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              armed,
    output logic              triggered,
    output logic              overflow
);
    cap_state_t state, nxt;

    logic [DATA_W-1:0] sample;
    logic [DATA_W-1:0] pat_val [N_PAT];
    logic [DATA_W-1:0] pat_msk [N_PAT];
    logic [N_PAT-1:0]  pat_hit;
    logic              arm_go, flush, trig_now, in_cap, store_en;
    logic              first_q, mark;
    logic [HALF_W-1:0] half;
    logic              half_valid;

    assign sample = in_data[DATA_W-1:0];

    always_comb begin
        pat_val[P_START] = start_value;
        pat_msk[P_START] = start_mask;
        pat_val[P_STORE] = store_value;
        pat_msk[P_STORE] = store_mask;
    end

    for (genvar g = 0; g < N_PAT; g++) begin : g_pat
        tcf_match #(.W(DATA_W)) u_match (
            .sample (sample),
            .value  (pat_val[g]),
            .mask   (pat_msk[g]),
            .hit    (pat_hit[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and control outputs
    always_comb begin
        nxt      = state;
        arm_go   = 1'b0;
        flush    = 1'b0;
        trig_now = 1'b0;
        in_cap   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (arm && !disarm) begin
                    nxt    = S_ARMED;
                    arm_go = 1'b1;
                end
            end
            S_ARMED: begin
                if (disarm) begin
                    nxt   = S_IDLE;
                    flush = 1'b1;
                end else if (in_valid && pat_hit[P_START]) begin
                    nxt      = S_CAPTURE;
                    trig_now = 1'b1;
                end
            end
            S_CAPTURE: begin
                if (disarm) begin
                    nxt   = S_IDLE;
                    flush = 1'b1;
                end else begin
                    in_cap = in_valid;
                end
            end
            default: nxt = S_IDLE;
        endcase
        store_en  = (in_cap || trig_now) && pat_hit[P_STORE];
        mark      = first_q || trig_now;
        armed     = (state != S_IDLE);
        triggered = (state == S_CAPTURE);
    end

    // marker pending between trigger and first stored sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (trig_now) begin
            first_q <= !store_en;
        end else if (store_en || flush || arm_go) begin
            first_q <= 1'b0;
        end
    end

    tcf_widen #(.W(DATA_W)) u_widen (
        .data    (sample),
        .odd_sel (odd_parity),
        .mark    (mark),
        .half    (half)
    );

    tcf_packer #(.HALF_W(HALF_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_ovf    (arm_go),
        .store_en   (store_en),
        .store_half (half),
        .flush      (flush),
        .fifo_full  (fifo_full),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .overflow   (overflow),
        .half_valid (half_valid)
    );

    AST_WR_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(state == S_CAPTURE)); // R6
    AST_TRIG_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> $past(state == S_ARMED)); // R3
    AST_IDLE_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !half_valid); // R7
    AST_NO_STORE_UNTRIGGERED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARMED && !in_valid) |=> !half_valid); // R9
endmodule

// File: tb/tb_trig_capture_fe.sv
module tb_trig_capture_fe;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [20:0] in_data;
    logic [13:0] start_value, start_mask, store_value, store_mask;
    logic        odd_parity, arm, disarm, fifo_full;
    logic        fifo_wr;
    logic [31:0] fifo_data;
    logic        armed, triggered, overflow;

    int tests = 0;
    int fails = 0;

    // bench model
    int          m_st;      // 0 idle, 1 armed, 2 capture
    bit          m_hv, m_first, m_ovf, e_wr;
    logic [15:0] m_half;
    logic [31:0] e_data;

    always #2 clk = ~clk;

    trig_capture_fe dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .start_value(start_value), .start_mask(start_mask),
        .store_value(store_value), .store_mask(store_mask),
        .odd_parity(odd_parity), .arm(arm), .disarm(disarm),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .armed(armed), .triggered(triggered), .overflow(overflow)
    );

    function automatic bit hits(logic [13:0] s, logic [13:0] v, logic [13:0] m);
        return ((s ^ v) & m) == 14'h0;
    endfunction

    function automatic logic [15:0] widen(logic [13:0] d, bit odd, bit mk);
        return {mk, (^d) ^ odd, d};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic emit(logic [31:0] w);
        if (fifo_full) m_ovf = 1'b1;
        else begin e_wr = 1'b1; e_data = w; end
    endtask

    task automatic model_edge();
        logic [13:0] s;
        bit trig, st;
        s = in_data[13:0];
        e_wr = 1'b0;
        if (m_st == 0) begin
            if (arm && !disarm) begin m_st = 1; m_ovf = 1'b0; m_first = 1'b0; end
        end else if (disarm) begin
            if (m_hv) emit({16'h0, m_half});
            m_hv = 1'b0; m_first = 1'b0; m_st = 0;
        end else if (in_valid) begin
            trig = (m_st == 1) && hits(s, start_value, start_mask);
            if (trig) begin m_st = 2; m_first = 1'b1; end
            st = (m_st == 2) && hits(s, store_value, store_mask);
            if (st) begin
                if (!m_hv) begin m_half = widen(s, odd_parity, m_first); m_hv = 1'b1; end
                else begin emit({widen(s, odd_parity, m_first), m_half}); m_hv = 1'b0; end
                m_first = 1'b0;
            end
        end
    endtask

    task automatic step(bit v, logic [20:0] d, bit a, bit da, bit full, string tag);
        in_valid = v; in_data = d; arm = a; disarm = da; fifo_full = full;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " wr"}, {31'h0, fifo_wr}, {31'h0, e_wr});
        if (e_wr) chk({tag, " data"}, fifo_data, e_data);
        chk({tag, " state"}, {30'h0, armed, triggered},
            {30'h0, m_st != 0, m_st == 2});
        chk({tag, " ovf"}, {31'h0, overflow}, {31'h0, m_ovf});
        in_valid = 1'b0; arm = 1'b0; disarm = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; in_valid = 0; in_data = 0; arm = 0; disarm = 0; fifo_full = 0;
        start_value = 14'h1234; start_mask = 14'h3FFF;
        store_value = 14'h0; store_mask = 14'h0; odd_parity = 1'b0;
        m_st = 0; m_hv = 0; m_first = 0; m_ovf = 0; e_wr = 0; m_half = 0; e_data = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", {28'h0, fifo_wr, armed, triggered, overflow}, 32'h0);
        rst_n = 1'b1;

        // R3: start pattern ignored while idle
        step(1, {7'h00, 14'h1234}, 0, 0, 0, "R3 idle");
        step(0, 21'h0, 1, 0, 0, "R2 arm");
        step(1, {7'h00, 14'h1235}, 0, 0, 0, "R3 miss");
        // R9: strobe low with matching data
        step(0, {7'h00, 14'h1234}, 0, 0, 0, "R9 novalid");
        // R3: upper bits differ, trigger and store with marker (R4 R5)
        step(1, {7'h7F, 14'h1234}, 0, 0, 0, "R3 trigger");
        step(1, {7'h01, 14'h0007}, 1, 0, 0, "R6 pair R2 arm ignored");
        // R4 filtered storage, R5 odd parity
        store_value = 14'h0005; store_mask = 14'h000F; odd_parity = 1'b1;
        step(1, 21'h0003, 0, 0, 0, "R4 reject");
        step(1, 21'h1F15, 0, 0, 0, "R4 keep");
        step(0, 21'h0, 0, 0, 0, "R9 idle cycle");
        step(1, 21'h0AA5, 0, 0, 1, "R8 full drop");
        step(1, 21'h0115, 0, 0, 0, "R4 keep lone");
        // R7: disarm flushes, sample in same cycle dropped, wins over arm
        step(1, 21'h0005, 1, 1, 0, "R7 flush");
        step(0, 21'h0, 0, 0, 0, "R8 sticky");
        step(0, 21'h0, 1, 0, 0, "R2 rearm clears");
        // trigger sample rejected by storage filter: marker goes on next kept
        store_value = 14'h0; store_mask = 14'h0001; odd_parity = 1'b0;
        start_value = 14'h0003; start_mask = 14'h000F;
        step(1, 21'h0013, 0, 0, 0, "R4 trig not kept");
        step(1, 21'h2222, 0, 0, 0, "R5 marker later");
        step(1, 21'h0001, 0, 0, 0, "R4 reject");
        step(0, 21'h0, 0, 1, 1, "R7 flush full R8");
        step(0, 21'h0, 0, 1, 0, "R7 disarm idle");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 300 == 0) begin
                start_value = 14'($urandom); start_mask = 14'($urandom & $urandom & $urandom);
                store_value = 14'($urandom);
                store_mask  = ($urandom % 4 == 0) ? 14'h0 : 14'($urandom & $urandom & $urandom);
                odd_parity  = 1'($urandom);
            end
            step(($urandom % 4) != 0, 21'($urandom), ($urandom % 16) == 0,
                 ($urandom % 60) == 0, ($urandom % 5) == 0, "R6 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule